// File: doc/BRIEF.md
# Round-Robin Channel Scanner

This block sits beside a converter that runs back to back and walks it through a ring of input channels with no software in the loop. The converter takes its channel select when a conversion begins, so the channel the scanner presents is always one conversion ahead of the result that is coming back. On each completion the scanner files the returned sample under the channel that was actually measured, one behind the current select, and moves the select on by one.

A start command loads the configuration bits that sit above the channel field, such as reference and justification choices. It also zeroes the channel field and empties the result table. After that, the first conversion-start strobe moves the select one step ahead. From then on every completion strobe writes one table entry and steps the select. The table has one entry per channel, each with a valid flag. It is read through a combinational address port, and a read that hits the entry being written in the same cycle returns the new sample.

Top module: `chan_scanner`

## Requirements
- R1: After reset the select output is all zeros, the scanner is idle, and every table entry reads as data 0 with valid 0.
- R2: A start command loads `cfg_i` into the upper select bits `sel_o[SEL_W-1:CH_W]`, sets the channel field `sel_o[CH_W-1:0]` to 0, and clears every entry to data 0 and valid 0. All of this is visible from the next cycle on.
- R3: The first `conv_start_i` after a start advances the channel field by one. Any later `conv_start_i` leaves the select unchanged.
- R4: Each completion accepted while running advances the channel field to (channel + 1) mod NCH, so channel NCH-1 wraps to 0.
- R5: An accepted completion writes `result_i` to entry (channel + NCH - 1) mod NCH, where channel is the value before the advance, and sets that entry's valid flag.
- R6: The upper select bits change only on a start command. Channel advances leave them unchanged.
- R7: A completion strobe has no effect on the select or the table while the scanner is idle, or after a start before the first `conv_start_i`.
- R8: `rd_data_o` and `rd_valid_o` show the entry at `rd_addr_i` in the same cycle. If that entry is being written in that cycle, they show the new sample with valid 1.
- R9: When a start command and a completion arrive in the same cycle, the start wins. Nothing is written and the channel field becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command: load configuration, clear table, arm |
| cfg_i | input | CFG_W | Configuration bits kept above the channel field |
| conv_start_i | input | 1 | Strobe: converter latched the select |
| conv_done_i | input | 1 | Strobe: conversion complete, `result_i` valid |
| result_i | input | RES_W | Converted sample |
| sel_o | output | CFG_W+CH_W | Select to the converter: {configuration, channel} |
| rd_addr_i | input | CH_W | Table read address |
| rd_data_o | output | RES_W | Sample stored at `rd_addr_i` |
| rd_valid_o | output | 1 | Entry at `rd_addr_i` has been written since the last start |

## Verification
The bench uses the default parameters: eight channels, 10-bit samples and three configuration bits. With these values a run of ten completions passes the wrap from channel 7 to 0 and touches every table entry. The narrow configuration field still lets two different start values show that the upper bits are held. Reads are aimed at the entry being written in some cycles and at other entries in others, so both the forwarding path and the stored path are compared against the model on every clock.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_ARMED = 2'd1,
      SC_RUN   = 2'd2
   } scan_state_e;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
   import chan_scan_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int CFG_W = 3,
   localparam int CH_W = $clog2(NCH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CFG_W-1:0] cfg_in,
   input  logic             conv_start,
   input  logic             conv_done,
   output logic [CH_W-1:0]  ch_o,
   output logic [CFG_W-1:0] cfg_o,
   output logic             wr_en,
   output logic [CH_W-1:0]  wr_idx
);
   scan_state_e      state_q;
   logic [CH_W-1:0]  ch_q;
   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         ch_q    <= '0;
         cfg_q   <= '0;
      end else if (start) begin
         state_q <= SC_ARMED;
         ch_q    <= '0;
         cfg_q   <= cfg_in;
      end else begin
         case (state_q)
            SC_ARMED: if (conv_start) begin
               state_q <= SC_RUN;
               ch_q    <= ch_q + 1'b1;
            end
            SC_RUN: if (conv_done) ch_q <= ch_q + 1'b1;
            default: ;
         endcase
      end
   end

   assign wr_en  = (state_q == SC_RUN) && conv_done && !start;
   assign wr_idx = ch_q - 1'b1;
   assign ch_o   = ch_q;
   assign cfg_o  = cfg_q;

   a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(cfg_q));
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ch_q == CH_W'($past(ch_q) + 1'b1));
   a_r3_arm_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SC_ARMED && conv_start && !start) |=> ch_q == CH_W'(1));
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SC_IDLE && !start) |=> $stable(ch_q));
   a_r9_start_first: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ch_q == '0);
endmodule

// File: rtl/scan_table.sv
module scan_table #(
   parameter int NCH   = 8,
   parameter int RES_W = 10,
   localparam int CH_W = $clog2(NCH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_idx,
   input  logic [RES_W-1:0] wr_data,
   input  logic [CH_W-1:0]  rd_idx,
   output logic [RES_W-1:0] rd_data,
   output logic             rd_vld
);
   logic [RES_W-1:0] data_q [NCH];
   logic [NCH-1:0]   vld_q;
   logic [NCH-1:0]   we;

   for (genvar g = 0; g < NCH; g++) begin : g_ent
      assign we[g] = wr_en && (wr_idx == CH_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            data_q[g] <= '0;
            vld_q[g]  <= 1'b0;
         end else if (we[g]) begin
            data_q[g] <= wr_data;
            vld_q[g]  <= 1'b1;
         end
      end
   end

   logic fwd;
   assign fwd     = wr_en && (wr_idx == rd_idx);
   assign rd_data = fwd ? wr_data : data_q[rd_idx];
   assign rd_vld  = fwd | vld_q[rd_idx];

   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> vld_q == '0);
   a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> vld_q[$past(wr_idx)] && data_q[$past(wr_idx)] == $past(wr_data));
   a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));
   a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == rd_idx) |-> (rd_vld && rd_data == wr_data));
endmodule

// File: rtl/chan_scanner.sv
module chan_scanner #(
   parameter int NCH   = 8,
   parameter int RES_W = 10,
   parameter int CFG_W = 3,
   localparam int CH_W  = $clog2(NCH),
   localparam int SEL_W = CFG_W + CH_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             conv_start_i,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] result_i,
   output logic [SEL_W-1:0] sel_o,
   input  logic [CH_W-1:0]  rd_addr_i,
   output logic [RES_W-1:0] rd_data_o,
   output logic             rd_valid_o
);
   if (NCH < 2 || (1 << CH_W) != NCH) begin : g_bad_nch
      $error("chan_scanner: NCH must be a power of two, at least 2");
   end
   if (RES_W < 1 || CFG_W < 1) begin : g_bad_w
      $error("chan_scanner: RES_W and CFG_W must be positive");
   end

   logic [CH_W-1:0]  ch;
   logic [CFG_W-1:0] cfg;
   logic             wr_en;
   logic [CH_W-1:0]  wr_idx;

   scan_seq #(.NCH(NCH), .CFG_W(CFG_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start_i), .cfg_in(cfg_i),
      .conv_start(conv_start_i), .conv_done(conv_done_i),
      .ch_o(ch), .cfg_o(cfg), .wr_en(wr_en), .wr_idx(wr_idx)
   );

   scan_table #(.NCH(NCH), .RES_W(RES_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .clr(start_i),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(result_i),
      .rd_idx(rd_addr_i), .rd_data(rd_data_o), .rd_vld(rd_valid_o)
   );

   assign sel_o = {cfg, ch};

   a_r9_no_write_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !wr_en);
endmodule

// File: tb/tb_chan_scanner.sv
module tb_chan_scanner;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, start_i, conv_start_i, conv_done_i, rd_valid_o;
   logic [2:0] cfg_i, rd_addr_i;
   logic [9:0] result_i, rd_data_o;
   logic [5:0] sel_o;

   chan_scanner dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
      .conv_start_i(conv_start_i), .conv_done_i(conv_done_i),
      .result_i(result_i), .sel_o(sel_o), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
   );

   int total = 0, bad = 0;
   bit finished = 0;
   int m_state = 0, m_ch = 0, m_cfg = 0;
   int m_val[8];
   bit m_vld[8];

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_vld[i] = 0; end
   endtask

   task automatic cyc(input string tag, input bit rs, input bit st, input int cfg,
                      input bit cs, input bit cd, input int res, input int ra);
      bit wr;
      int wi;
      @(negedge clk);
      rst_n = !rs; start_i = st; cfg_i = 3'(cfg); conv_start_i = cs;
      conv_done_i = cd; result_i = 10'(res); rd_addr_i = 3'(ra);
      #1;
      wr = !rs && !st && m_state == 2 && cd;
      wi = (m_ch + 7) % 8;
      chk(tag, sel_o, m_cfg * 8 + m_ch);
      if (wr && wi == ra) begin
         chk("R8 data", rd_data_o, res);
         chk("R8 valid", rd_valid_o, 1);
      end else begin
         chk("R5 data", rd_data_o, m_val[ra]);
         chk("R5 valid", rd_valid_o, m_vld[ra]);
      end
      @(posedge clk);
      if (rs) begin
         m_state = 0; m_ch = 0; m_cfg = 0; model_clear();
      end else if (st) begin
         m_state = 1; m_ch = 0; m_cfg = cfg; model_clear();
      end else if (m_state == 1 && cs) begin
         m_state = 2; m_ch = (m_ch + 1) % 8;
      end else if (wr) begin
         m_val[wi] = res; m_vld[wi] = 1; m_ch = (m_ch + 1) % 8;
      end
   endtask

   initial begin
      #100000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      for (int i = 0; i < 3; i++) cyc("R1 reset", 1, 0, 0, 0, 0, 0, i);
      // R7: completions while idle are ignored
      cyc("R7 idle", 0, 0, 0, 0, 1, 111, 7);
      cyc("R7 idle", 0, 0, 0, 1, 1, 222, 0);
      // R2: start loads cfg and clears
      cyc("R2 start", 0, 1, 5, 0, 0, 0, 0);
      // R7: done before first conversion start ignored
      cyc("R7 armed", 0, 0, 6, 0, 1, 333, 7);
      // R3: first conversion start advances, later ones do not
      cyc("R3 first", 0, 0, 6, 1, 0, 0, 0);
      cyc("R3 later", 0, 0, 6, 1, 0, 0, 0);
      cyc("R3 later", 0, 0, 6, 1, 0, 0, 1);
      // R4/R5/R6: ten completions, wrap past channel 7, mixed reads
      for (int k = 0; k < 10; k++) begin
         cyc("R4 step", 0, 0, 7, (k % 2) == 1, 1, 100 + k * 37, (k % 3 == 0) ? k % 8 : (k + 3) % 8);
         cyc("R6 hold", 0, 0, 2, 0, 0, 0, k % 8);
      end
      for (int i = 0; i < 8; i++) cyc("R5 table", 0, 0, 0, 0, 0, 0, i);
      // R9: start together with done
      cyc("R9 start wins", 0, 1, 2, 0, 1, 999, 3);
      for (int i = 0; i < 8; i++) cyc("R9 cleared", 0, 0, 0, 0, 1, 500 + i, i);
      cyc("R3 rearm", 0, 0, 0, 1, 0, 0, 0);
      cyc("R4 step", 0, 0, 0, 0, 1, 77, 0);
      cyc("R5 after", 0, 0, 0, 0, 0, 0, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule